// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Strobe Mode

This block carries words from a write clock domain to an independent read clock domain. The storage is a small array with one write port and one read port. Both pointers are one bit wider than the address. Each pointer is converted to Gray code before it crosses to the other domain through a two-flop synchronizer. Each side derives its own status flags by comparing its local pointer with the synchronized copy of the remote pointer.

A build-time parameter selects how the read strobe behaves. In acknowledge (show-ahead) mode, the oldest stored word already sits on the read data output, and the strobe consumes it and moves to the next word. In request mode, the strobe fetches the oldest word into an output register, and that word appears one read clock later.

The write side reports a full flag, an empty flag and a level bus, all registered in the write clock. The level bus is log2(depth) bits wide, and the full flag serves as its missing top bit.

Top module: `xclk_fifo`

## Requirements
- R1: After both resets, wr_full_o=0, wr_empty_o=1, wr_level_o=0 and rd_empty_o=1. In request mode rd_data_o=0.
- R2: Words leave the FIFO in the order they were accepted. No word is lost and no word is repeated.
- R3: A write strobe while wr_full_o=1 is ignored: no word is stored, and the write pointer does not move.
- R4: A read strobe while rd_empty_o=1 is ignored: the read pointer does not move, and the next word written is the next word read.
- R5: wr_level_o is registered. One write clock after each write edge, it equals the number of words accepted minus the read count as seen through the two-flop synchronizer. When that count equals the depth, wr_level_o shows 0 and wr_full_o shows 1.
- R6: wr_full_o is 1 exactly when the write-side count equals the depth. Because the read pointer reaches the write side late, wr_full_o may stay high for extra write clocks after a read.
- R7: wr_empty_o is 1 exactly when the write-side count is zero.
- R8: rd_empty_o is 1 exactly when the read pointer equals the write pointer after two read-clock synchronizer stages. A written word becomes readable at the second read edge after the write edge.
- R9: With ACK_MODE=1, while rd_empty_o=0, rd_data_o carries the oldest unread word. An accepted strobe moves the output to the following word.
- R10: With ACK_MODE=0, an accepted strobe loads the oldest unread word into rd_data_o at that read edge. The value is held until the next accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write domain clock |
| wr_rst_ni | input | 1 | Write domain asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DW | Write word |
| wr_full_o | output | 1 | Full flag; also the top bit of the level |
| wr_empty_o | output | 1 | Write-side empty flag |
| wr_level_o | output | AW | Stored word count, low bits |
| rd_clk_i | input | 1 | Read domain clock |
| rd_rst_ni | input | 1 | Read domain asynchronous reset, active low |
| rd_i | input | 1 | Read strobe (request or acknowledge) |
| rd_data_o | output | DW | Read word |
| rd_empty_o | output | 1 | Read-side empty flag |

## Verification
The assertions assume the two resets are held together from time zero and that both clocks run freely. They place no limit on the strobes: writes while full and reads while empty are legal stimulus, and the assertions check that such strobes move nothing. The clock periods are chosen so that no write edge ever coincides with a read edge, which keeps the synchronizer delay deterministic. The stimulus runs one phase that reads an empty FIFO, one that overfills it, and random phases at balanced and skewed rates. Two instances, one per read mode, are driven in parallel and compared against a bench model of the pointer synchronization.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/xclk_fifo_mem.sv
module xclk_fifo_mem #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          wr_clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/xclk_fifo_wr.sv
module xclk_fifo_wr
  import xclk_fifo_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          wr_clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW:0]   rgray_sync_i,
  output logic          mem_we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [AW-1:0] level_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, rbin_s, level_q, level_d;

  assign full_o   = level_q[AW];
  assign level_o  = level_q[AW-1:0];
  assign empty_o  = (level_q == '0);
  assign mem_we_o = wr_en_i && !full_o;
  assign wbin_d   = wbin_q + PW'(mem_we_o);
  assign rbin_s   = PW'(gray_to_bin(32'(rgray_sync_i)));
  // count after this edge, seen against the lagging read pointer
  assign level_d  = wbin_d - rbin_s;

  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      level_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wbin_d ^ (wbin_d >> 1);
      level_q <= level_d;
    end
  end

  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;

  a_r3_no_write_when_full: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i) |=> $stable(wbin_q));
  a_r2_wgray_step: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    $onehot0(wgray_q ^ $past(wgray_q)));
  a_r5_full_level_zero: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    full_o |-> (level_o == '0));
endmodule

// File: rtl/xclk_fifo_rd.sv
module xclk_fifo_rd
  import xclk_fifo_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 3,
  parameter bit ACK_MODE = 1'b1
) (
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [AW:0]   wgray_sync_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic          empty_o,
  output logic [DW-1:0] rdata_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin_q, rbin_d, rgray_q, wbin_s;
  logic          rd_go;

  assign wbin_s  = PW'(gray_to_bin(32'(wgray_sync_i)));
  assign empty_o = (rbin_q == wbin_s);
  assign rd_go   = rd_i && !empty_o;
  assign rbin_d  = rbin_q + PW'(rd_go);

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;

  generate
    if (ACK_MODE) begin : g_ack
      // head word shown ahead of the strobe
      assign rdata_o = mem_rdata_i;
    end else begin : g_req
      logic [DW-1:0] rdata_q;
      always_ff @(posedge rd_clk_i or negedge rst_ni) begin
        if (!rst_ni)    rdata_q <= '0;
        else if (rd_go) rdata_q <= mem_rdata_i;
      end
      assign rdata_o = rdata_q;
    end
  endgenerate

  a_r4_no_read_when_empty: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (empty_o && rd_i) |=> $stable(rbin_q));
  a_r2_rgray_step: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $onehot0(rgray_q ^ $past(rgray_q)));
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int DW       = 8,
  parameter int AW       = 3,
  parameter bit ACK_MODE = 1'b1
) (
  input  logic          wr_clk_i,
  input  logic          wr_rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_full_o,
  output logic          wr_empty_o,
  output logic [AW-1:0] wr_level_o,
  input  logic          rd_clk_i,
  input  logic          rd_rst_ni,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_empty_o
);
  localparam int PW = AW + 1;

  logic          mem_we;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem_rdata;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

  xclk_fifo_mem #(.DW(DW), .AW(AW)) i_mem (
    .wr_clk_i (wr_clk_i),
    .we_i     (mem_we),
    .waddr_i  (waddr),
    .wdata_i  (wr_data_i),
    .raddr_i  (raddr),
    .rdata_o  (mem_rdata)
  );

  xclk_fifo_sync #(.W(PW)) i_sync_r2w (
    .clk_i  (wr_clk_i),
    .rst_ni (wr_rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_s)
  );

  xclk_fifo_sync #(.W(PW)) i_sync_w2r (
    .clk_i  (rd_clk_i),
    .rst_ni (rd_rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_s)
  );

  xclk_fifo_wr #(.AW(AW)) i_wr (
    .wr_clk_i     (wr_clk_i),
    .rst_ni       (wr_rst_ni),
    .wr_en_i      (wr_en_i),
    .rgray_sync_i (rgray_s),
    .mem_we_o     (mem_we),
    .waddr_o      (waddr),
    .wgray_o      (wgray),
    .full_o       (wr_full_o),
    .empty_o      (wr_empty_o),
    .level_o      (wr_level_o)
  );

  xclk_fifo_rd #(.DW(DW), .AW(AW), .ACK_MODE(ACK_MODE)) i_rd (
    .rd_clk_i     (rd_clk_i),
    .rst_ni       (rd_rst_ni),
    .rd_i         (rd_i),
    .wgray_sync_i (wgray_s),
    .mem_rdata_i  (mem_rdata),
    .raddr_o      (raddr),
    .rgray_o      (rgray),
    .empty_o      (rd_empty_o),
    .rdata_o      (rd_data_o)
  );
endmodule

// File: tb/test_xclk_fifo.sv
module test_xclk_fifo;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic full_a, wempty_a, rempty_a, full_q, wempty_q, rempty_q;
  logic [AW-1:0] level_a, level_q;
  logic [DW-1:0] rdata_a, rdata_q;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 wr_clk = ~wr_clk;
  initial begin
    #2;
    forever begin rd_clk = 1'b1; #7; rd_clk = 1'b0; #7; end
  end

  xclk_fifo #(.DW(DW), .AW(AW), .ACK_MODE(1'b1)) i_xclk_fifo (
    .wr_clk_i(wr_clk), .wr_rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_full_o(full_a), .wr_empty_o(wempty_a), .wr_level_o(level_a),
    .rd_clk_i(rd_clk), .rd_rst_ni(rst_n), .rd_i(rd), .rd_data_o(rdata_a),
    .rd_empty_o(rempty_a));

  xclk_fifo #(.DW(DW), .AW(AW), .ACK_MODE(1'b0)) i_xclk_fifo_req (
    .wr_clk_i(wr_clk), .wr_rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_full_o(full_q), .wr_empty_o(wempty_q), .wr_level_o(level_q),
    .rd_clk_i(rd_clk), .rd_rst_ni(rst_n), .rd_i(rd), .rd_data_o(rdata_q),
    .rd_empty_o(rempty_q));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] q[$];
  int m_wcnt, m_rs1, m_rs2, m_wlev;
  int m_rcnt, m_ws1, m_ws2;
  logic [DW-1:0] m_req;

  always @(posedge wr_clk or negedge rst_n) begin : wmodel
    int acc, nw;
    if (!rst_n) begin
      m_wcnt <= 0; m_rs1 <= 0; m_rs2 <= 0; m_wlev <= 0;
      q.delete();
    end else begin
      acc = (wr_en && m_wlev != DEPTH) ? 1 : 0;
      nw = m_wcnt + acc;
      if (acc == 1) q.push_back(wr_data);
      m_wcnt <= nw;
      m_wlev <= nw - m_rs2;
      m_rs2 <= m_rs1;
      m_rs1 <= m_rcnt;
    end
  end

  always @(posedge rd_clk or negedge rst_n) begin : rmodel
    if (!rst_n) begin
      m_rcnt <= 0; m_ws1 <= 0; m_ws2 <= 0; m_req <= '0;
    end else begin
      if (rd && m_rcnt != m_ws2) begin
        m_req <= q[0];
        void'(q.pop_front());
        m_rcnt <= m_rcnt + 1;
      end
      m_ws2 <= m_ws1;
      m_ws1 <= m_wcnt;
    end
  end

  // per-clock comparison, write domain
  always @(posedge wr_clk) begin
    #4;
    if (rst_n && !done) begin
      chk("R6 full ack", int'(full_a), int'(m_wlev == DEPTH));
      chk("R6 full req", int'(full_q), int'(m_wlev == DEPTH));
      chk("R5 level ack", int'(level_a), m_wlev % DEPTH);
      chk("R5 level req", int'(level_q), m_wlev % DEPTH);
      chk("R7 wr_empty ack", int'(wempty_a), int'(m_wlev == 0));
      chk("R7 wr_empty req", int'(wempty_q), int'(m_wlev == 0));
    end
  end

  // per-clock comparison, read domain
  always @(posedge rd_clk) begin
    #4;
    if (rst_n && !done) begin
      chk("R8 rd_empty ack", int'(rempty_a), int'(m_rcnt == m_ws2));
      chk("R8 rd_empty req", int'(rempty_q), int'(m_rcnt == m_ws2));
      if (m_rcnt != m_ws2) chk("R2 R9 head word", int'(rdata_a), int'(q[0]));
      chk("R2 R10 request word", int'(rdata_q), int'(m_req));
    end
  end

  task automatic wr_cycles(input int n, input bit en, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en = en;
      wr_data = DW'(base + i);
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      rd = 1'b1;
    end
    @(negedge rd_clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge wr_clk);
    @(negedge wr_clk);
    #1 rst_n = 1'b1;
    @(posedge wr_clk);
    #4;
    chk("R1 full", int'(full_a), 0);
    chk("R1 wr_empty", int'(wempty_a), 1);
    chk("R1 level", int'(level_q), 0);
    chk("R1 rd_empty", int'(rempty_q), 1);
    chk("R1 request data", int'(rdata_q), 0);

    // R4: strobes on an empty FIFO
    rd_cycles(6);
    wr_cycles(1, 1'b1, 8'h3c);
    repeat (6) @(posedge rd_clk);
    #4;
    chk("R4 head after empty strobes", int'(rdata_a), 8'h3c);
    rd_cycles(1);
    @(posedge rd_clk);
    #4;
    chk("R4 request after empty strobes", int'(rdata_q), 8'h3c);
    repeat (6) @(posedge wr_clk);

    // R3 R5 R6: overfill
    wr_cycles(DEPTH + 4, 1'b1, 8'h40);
    repeat (3) @(posedge wr_clk);
    #4;
    chk("R6 full after overfill", int'(full_a), 1);
    chk("R5 level wraps to 0 at depth", int'(level_a), 0);
    rd_cycles(DEPTH);
    @(posedge rd_clk);
    #4;
    chk("R3 no extra word stored", int'(rempty_a), 1);
    chk("R3 last word is depth-th", int'(rdata_q), 8'h40 + DEPTH - 1);
    repeat (8) @(posedge wr_clk);

    // random traffic, balanced then write-heavy
    for (int ph = 0; ph < 2; ph++) begin
      fork
        for (int i = 0; i < 1500; i++) begin
          @(negedge wr_clk);
          wr_en = (($urandom % 10) < (ph == 0 ? 5 : 8));
          wr_data = DW'($urandom);
        end
        for (int i = 0; i < 1100; i++) begin
          @(negedge rd_clk);
          rd = (($urandom % 10) < (ph == 0 ? 6 : 3));
        end
      join
      @(negedge wr_clk) wr_en = 1'b0;
      rd_cycles(40);
      repeat (10) @(posedge wr_clk);
    end
    #4;
    chk("R7 wr_empty after drain", int'(wempty_a), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule